// File: doc/BRIEF.md
# Multi-Compare Prescaled Timer

A 16-bit counter that steps up or down once for every programmable number of reference ticks. A slow reference supplies a one-cycle tick-enable pulse, and a prescaler turns those pulses into count steps. Six compare registers watch the counter. Each one raises its own status bit when a count step lands on its value. A write-1-to-clear status register and a mask register combine into one interrupt request.

Software picks one of three completion behaviours through a 3-bit mode field:
- The counter runs down to zero and then halts.
- The counter completes on one selected compare value and then reloads the value last written to it.
- The counter wraps freely and never completes.

Everything is reached over a simple single-cycle register bus. Writes are strobed by a write enable, and reads are combinational from the address.

Top module: `mcp_timer`

## Requirements
- R1: After synchronous reset the following all read zero: counter, reload shadow, divider, compares, status and mask. The control register reads 0x10, meaning frozen, counting down, mode 0. The interrupt output is low.
- R2: The divider register holds ticks-per-step minus one. With value D, the counter steps once every D+1 cycles in which tick_en is high. Cycles with tick_en low do not advance the prescaler. Writing the divider restarts the prescaler.
- R3: While control bit 4 (freeze) is 1, neither the counter nor the prescaler moves, whatever tick_en does.
- R4: Control bit 3 selects the direction: 1 counts up, 0 counts down. Both directions wrap modulo 2^16.
- R5: Mode (control bits 2..0) equal to 0 makes the counter step until it lands on zero. It then holds at zero and makes no further steps.
- R6: Mode k in 1..6 selects compare k. A step taken while the counter equals compare k loads the shadow value instead of stepping.
- R7: Mode 7 counts freely and never reloads or stops.
- R8: A write to address 0 loads the counter and the shadow with the written value and restarts the prescaler. The write takes priority over a step in the same cycle.
- R9: A step whose new counter value equals compare k (k = 1..6) sets status bit k-1, in every mode. Neither a frozen counter nor a direct counter write sets any bit.
- R10: Writing 1 to a status bit clears it. If a set and a clear hit the same bit in one cycle, the bit ends up set.
- R11: irq is high exactly when some status bit and its mask bit are both 1.
- R12: Register addresses:
  - 0 counter (reads the live count)
  - 1 divider
  - 2 control, 5 bits: {freeze, up, mode[2:0]}
  - 3 status, 6 bits
  - 4 mask, 6 bits
  - 5..10 compares 1..6
  - any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse from the slow tick reference |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the register at addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit count, six compares and a 4-bit address. At this width the wrap across 0xFFFF and 0x0000 is reached in a few steps by preloading the counter near the edge. Divider values 0, 2 and 3 make single-tick stepping, reload after a compare landing, and a step that coincides with a counter write all land within a handful of cycles. Because several compares can share one value, a single step can set more than one status bit at once, and the bench exercises that case together with a same-cycle clear.

// File: rtl/mcp_timer_pkg.sv
package mcp_timer_pkg;

    localparam int DEF_CNT_W  = 16;
    localparam int DEF_N_CMP  = 6;
    localparam int DEF_ADDR_W = 4;

    typedef enum logic [DEF_ADDR_W-1:0] {
        REG_COUNT    = 4'd0,
        REG_DIV      = 4'd1,
        REG_CTRL     = 4'd2,
        REG_STAT     = 4'd3,
        REG_MASK     = 4'd4,
        REG_CMP_BASE = 4'd5
    } reg_addr_e;

    typedef struct packed {
        logic       freeze;
        logic       up;
        logic [2:0] mode;
    } ctrl_t;

    localparam logic [2:0] MODE_STOP_ZERO = 3'd0;
    localparam ctrl_t CTRL_RESET = '{freeze: 1'b1, up: 1'b0, mode: MODE_STOP_ZERO};

    function automatic logic [DEF_ADDR_W-1:0] cmp_addr(input int k);
        return DEF_ADDR_W'(int'(REG_CMP_BASE) + k);
    endfunction

endpackage

// File: rtl/mcp_prescaler.sv
module mcp_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         step
);

    logic [W-1:0] acc_q;

    assign step = run && (acc_q == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (run) begin
            acc_q <= step ? '0 : acc_q + W'(1);
        end
    end

    // R2
    presc_range_chk: assert property (@(posedge clk) disable iff (rst)
        acc_q <= limit);

    // R3
    presc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(acc_q));

endmodule

// File: rtl/mcp_count_core.sv
module mcp_count_core
    import mcp_timer_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 6
) (
    input  logic [W-1:0]        count,
    input  logic [W-1:0]        shadow,
    input  logic [N-1:0][W-1:0] cmp,
    input  ctrl_t               ctrl,
    input  logic                step,
    output logic                adv,
    output logic [W-1:0]        next,
    output logic [N-1:0]        hit
);

    logic [N-1:0] eq_now;
    logic [N-1:0] sel;
    logic         at_rest;
    logic         reload;
    logic [W-1:0] stepped;

    generate
        for (genvar k = 0; k < N; k++) begin : g_cmp
            assign eq_now[k] = (count == cmp[k]);
            assign sel[k]    = (int'(ctrl.mode) == k + 1);
            assign hit[k]    = adv && (next == cmp[k]);
        end
    endgenerate

    assign at_rest = (ctrl.mode == MODE_STOP_ZERO) && (count == '0);
    assign reload  = |(eq_now & sel);
    assign stepped = ctrl.up ? count + W'(1) : count - W'(1);
    assign next    = reload ? shadow : stepped;
    assign adv     = step && !at_rest;

endmodule

// File: rtl/mcp_irq_status.sv
module mcp_irq_status #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= (status & ~clr) | set;
        end
    end

    assign irq = |(status & mask);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|set) |=> ((status & $past(set)) == $past(set)));

    // R10
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr & ~set)) |=> ((status & $past(clr & ~set)) == '0));

endmodule

// File: rtl/mcp_timer.sv
module mcp_timer
    import mcp_timer_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int N_CMP  = DEF_N_CMP,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq
);

    localparam int CTRL_W = $bits(ctrl_t);

    logic [CNT_W-1:0]            count_q;
    logic [CNT_W-1:0]            shadow_q;
    logic [CNT_W-1:0]            div_q;
    ctrl_t                       ctrl_q;
    logic [N_CMP-1:0]            mask_q;
    logic [N_CMP-1:0][CNT_W-1:0] cmp_q;
    logic [N_CMP-1:0]            status;

    logic             wr_cnt, wr_div, wr_ctrl, wr_stat, wr_mask;
    logic [N_CMP-1:0] wr_cmp;
    logic             step, adv;
    logic [CNT_W-1:0] next_val;
    logic [N_CMP-1:0] hit;
    logic [N_CMP-1:0] clr;

    assign wr_cnt  = wr_en && (addr == ADDR_W'(REG_COUNT));
    assign wr_div  = wr_en && (addr == ADDR_W'(REG_DIV));
    assign wr_ctrl = wr_en && (addr == ADDR_W'(REG_CTRL));
    assign wr_stat = wr_en && (addr == ADDR_W'(REG_STAT));
    assign wr_mask = wr_en && (addr == ADDR_W'(REG_MASK));
    assign clr     = wr_stat ? wdata[N_CMP-1:0] : '0;

    generate
        for (genvar k = 0; k < N_CMP; k++) begin : g_cmp_reg
            assign wr_cmp[k] = wr_en && (addr == ADDR_W'(cmp_addr(k)));
            always_ff @(posedge clk) begin
                if (rst) begin
                    cmp_q[k] <= '0;
                end else if (wr_cmp[k]) begin
                    cmp_q[k] <= wdata;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            shadow_q <= '0;
            div_q    <= '0;
            ctrl_q   <= CTRL_RESET;
            mask_q   <= '0;
        end else begin
            if (wr_cnt) begin
                count_q  <= wdata;
                shadow_q <= wdata;
            end else if (adv) begin
                count_q <= next_val;
            end
            if (wr_div)  div_q  <= wdata;
            if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (wr_mask) mask_q <= wdata[N_CMP-1:0];
        end
    end

    mcp_prescaler #(.W(CNT_W)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .run   (tick_en && !ctrl_q.freeze),
        .clear (wr_cnt || wr_div),
        .limit (div_q),
        .step  (step)
    );

    mcp_count_core #(.W(CNT_W), .N(N_CMP)) u_core (
        .count  (count_q),
        .shadow (shadow_q),
        .cmp    (cmp_q),
        .ctrl   (ctrl_q),
        .step   (step),
        .adv    (adv),
        .next   (next_val),
        .hit    (hit)
    );

    mcp_irq_status #(.N(N_CMP)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .set    (hit),
        .clr    (clr),
        .mask   (mask_q),
        .status (status),
        .irq    (irq)
    );

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(REG_COUNT))     rdata = count_q;
        else if (addr == ADDR_W'(REG_DIV))  rdata = div_q;
        else if (addr == ADDR_W'(REG_CTRL)) rdata = CNT_W'(ctrl_q);
        else if (addr == ADDR_W'(REG_STAT)) rdata = CNT_W'(status);
        else if (addr == ADDR_W'(REG_MASK)) rdata = CNT_W'(mask_q);
        for (int k = 0; k < N_CMP; k++) begin
            if (addr == ADDR_W'(cmp_addr(k))) rdata = cmp_q[k];
        end
    end

    // R3
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.freeze && !wr_cnt) |=> $stable(count_q));

    // R5
    zero_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == MODE_STOP_ZERO && count_q == '0 && !wr_cnt) |=> (count_q == '0));

    // R8
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (count_q == $past(wdata) && shadow_q == $past(wdata)));

endmodule

// File: tb/mcp_timer_test.sv
module mcp_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mcp_timer uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // behavioural reference model
    logic [15:0] m_cnt, m_sh, m_div, m_pre;
    logic [4:0]  m_ctl;
    logic [5:0]  m_st, m_mk;
    logic [15:0] m_cmp [6];

    always @(posedge clk) begin : model
        logic        stp;
        logic [15:0] nv;
        logic [5:0]  hit, clr;
        int          mode;
        if (rst) begin
            m_cnt = 0; m_sh = 0; m_div = 0; m_pre = 0;
            m_ctl = 5'h10; m_st = 0; m_mk = 0;
            for (int k = 0; k < 6; k++) m_cmp[k] = 0;
        end else begin
            stp = 0; hit = 0; clr = 0;
            if (!m_ctl[4] && tick_en) begin
                if (m_pre == m_div) begin m_pre = 0; stp = 1; end
                else m_pre = m_pre + 16'd1;
            end
            if (stp) begin
                mode = int'(m_ctl[2:0]);
                if (!(mode == 0 && m_cnt == 16'd0)) begin
                    if (mode >= 1 && mode <= 6 && m_cnt == m_cmp[mode-1]) nv = m_sh;
                    else if (m_ctl[3]) nv = m_cnt + 16'd1;
                    else nv = m_cnt - 16'd1;
                    for (int k = 0; k < 6; k++) if (nv == m_cmp[k]) hit[k] = 1'b1;
                    m_cnt = nv;
                end
            end
            if (wr_en) begin
                case (addr)
                    4'd0: begin m_cnt = wdata; m_sh = wdata; m_pre = 0; end
                    4'd1: begin m_div = wdata; m_pre = 0; end
                    4'd2: m_ctl = wdata[4:0];
                    4'd3: clr = wdata[5:0];
                    4'd4: m_mk = wdata[5:0];
                    default: if (addr >= 4'd5 && addr <= 4'd10) m_cmp[int'(addr) - 5] = wdata;
                endcase
            end
            m_st = (m_st & ~clr) | hit;
        end
    end

    function automatic logic [15:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return m_cnt;
            4'd1: return m_div;
            4'd2: return {11'd0, m_ctl};
            4'd3: return {10'd0, m_st};
            4'd4: return {10'd0, m_mk};
            default: return (a >= 4'd5 && a <= 4'd10) ? m_cmp[int'(a) - 5] : 16'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always begin
        @(negedge clk);
        #3;
        if (!rst && !done) begin
            check("R11 irq vs model", {15'd0, irq}, {15'd0, |(m_st & m_mk)});
            check("R12 rdata vs model", rdata, m_read(addr));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; tick_en = 1'b0; addr = a; wdata = d;
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            wr_en = 1'b0; tick_en = 1'b1;
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0; addr = a;
        #2;
        v = rdata;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd2, v); check("R1 ctrl", v, 16'h0010);
        rd(4'd0, v); check("R1 count", v, 16'h0000);
        rd(4'd3, v); check("R1 status", v, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'd0);

        // R6 / R9 / R11: mode 1, up, divider 2
        wr(4'd1, 16'd2); wr(4'd5, 16'd5); wr(4'd0, 16'd1); wr(4'd4, 16'd1); wr(4'd2, 16'h0009);
        tick(12);
        rd(4'd0, v); check("R2 R6 count at compare", v, 16'd5);
        rd(4'd3, v); check("R9 status bit0", v, 16'h0001);
        check("R11 irq high", {15'd0, irq}, 16'd1);
        tick(3);
        rd(4'd0, v); check("R6 reload from shadow", v, 16'd1);
        wr(4'd3, 16'h0001);
        rd(4'd3, v); check("R10 w1c", v, 16'h0000);

        // R10 set wins over clear
        wr(4'd2, 16'h001F); wr(4'd1, 16'd0); wr(4'd0, 16'd4); wr(4'd6, 16'd5);
        wr(4'd3, 16'h003F); wr(4'd2, 16'h000F);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; addr = 4'd3; wdata = 16'h0002;
        rd(4'd3, v); check("R10 set wins", v, 16'h0003);

        // R3 freeze
        wr(4'd2, 16'h001F);
        tick(10);
        rd(4'd0, v); check("R3 frozen count", v, 16'd5);

        // R9 no hit when frozen or on direct write
        wr(4'd3, 16'h003F); wr(4'd0, 16'd5);
        tick(5);
        rd(4'd3, v); check("R9 no hit frozen", v, 16'h0000);

        // R5 count to zero and stop
        wr(4'd0, 16'd3); wr(4'd2, 16'h0000);
        tick(5);
        rd(4'd0, v); check("R5 stop at zero", v, 16'd0);

        // R7 free run wrap up, R4 down
        wr(4'd0, 16'hFFFE); wr(4'd2, 16'h000F);
        tick(3);
        rd(4'd0, v); check("R7 wrap up", v, 16'h0001);
        wr(4'd0, 16'd1); wr(4'd2, 16'h0007);
        tick(2);
        rd(4'd0, v); check("R4 wrap down", v, 16'hFFFF);

        // R2 divider
        wr(4'd2, 16'h001F); wr(4'd0, 16'd0); wr(4'd1, 16'd3); wr(4'd2, 16'h000F);
        tick(7);
        rd(4'd0, v); check("R2 one step in 7 ticks", v, 16'd1);
        tick(1);
        rd(4'd0, v); check("R2 second step", v, 16'd2);

        // R8 counter write restarts prescaler
        tick(2);
        wr(4'd0, 16'd10);
        tick(3);
        rd(4'd0, v); check("R8 prescaler restarted", v, 16'd10);
        tick(1);
        rd(4'd0, v); check("R8 step after restart", v, 16'd11);

        // R11 masking
        wr(4'd2, 16'h001F); wr(4'd3, 16'h003F); wr(4'd0, 16'd4); wr(4'd1, 16'd0);
        wr(4'd2, 16'h000F);
        tick(1);
        wr(4'd4, 16'd0);
        rd(4'd3, v); check("R9 two bits", v, 16'h0003);
        check("R11 masked irq low", {15'd0, irq}, 16'd0);
        wr(4'd4, 16'h0002);
        rd(4'd3, v); check("R11 unmasked irq high", {15'd0, irq}, 16'd1);

        // R6 mode 6, down
        wr(4'd2, 16'h001F); wr(4'd10, 16'd18); wr(4'd0, 16'd20); wr(4'd2, 16'h0006);
        tick(2);
        rd(4'd0, v); check("R6 mode6 at compare", v, 16'd18);
        rd(4'd3, v); check("R9 status bit5", {15'd0, v[5]}, 16'd1);
        tick(1);
        rd(4'd0, v); check("R6 mode6 reload", v, 16'd20);

        // R12 map
        rd(4'd10, v); check("R12 compare6 readback", v, 16'd18);
        rd(4'd11, v); check("R12 unmapped reads zero", v, 16'd0);
        rd(4'd2, v);  check("R12 control readback", v, 16'h0006);

        finish_run();
    end

endmodule